// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a 16-bit count register paired with a 16-bit reload/capture register. One counter runs in one of four modes: capture, up-only auto-reload, up/down auto-reload, or baud-rate generation for a serial port. Each mode has its own handling of the overflow flag and the external flag. The count advances on one of two sources:
- falling edges of an external count pin;
- a timer tick taken from the system clock through a selectable prescaler (divide by 1, 16 or 256), followed by a divide-by-12 stage, or a divide-by-4 stage when the fast bit is set.

A second external pin has two uses. In capture, reload and baud modes its falling edge is an event. In up/down mode its level gives the count direction.

Software reaches every register through a byte-wide bus with a combinational read port. The two status flags are sticky. The interrupt request is formed from the two flags, and the external flag is left out of it in up/down mode. In baud mode the block gives a one-cycle pulse on every rollover, for use by a serial port.

Top module: `flex_timer16`

## Requirements
- R1: After reset every register reads 0, and `irqReq`, `ovfFlag`, `extFlag` and `baudPulse` are 0.
- R2: Counting happens only while run (reg 0 bit 0) is 1. With the pin select (reg 0 bit 1) at 1, the count advances once for each falling edge of `cntPin`. A falling edge is a synchronized 1 followed by a synchronized 0, seen after a two-flop synchronizer. With the pin select at 0, the count advances once every P×D clocks. P is 1, 16 or 256 from reg 1 bits [4:3] (0, 1, 2 or 3). D is 4 when reg 1 bit 2 is 1 and 12 otherwise.
- R3: Capture mode is selected by reg 0 bit 2 = 1 with both clock-select bits (reg 0 bits 4 and 5) at 0. In this mode the count goes up and wraps from FFFFh to 0000h, and the wrap sets the overflow flag (reg 0 bit 6).
- R4: In capture mode with external enable (reg 0 bit 3) set, a falling edge of `trigPin` copies the count into the reload pair and sets the external flag (reg 0 bit 7). With external enable clear, such an edge changes nothing.
- R5: In capture mode with auto-clear (reg 1 bit 1) set, a capture also sets the count to 0000h.
- R6: Up-only reload mode is selected by reg 0 bit 2 = 0 and down enable (reg 1 bit 0) = 0. Rollover from FFFFh loads the reload pair and sets the overflow flag. A `trigPin` falling edge with external enable set also loads the reload pair and sets the external flag.
- R7: Up/down mode is selected by reg 0 bit 2 = 0 and down enable = 1. A synchronized `trigPin` level of 1 counts up, and 0 counts down. An up count at FFFFh loads the reload pair.
- R8: In up/down mode, a down count taken while the count equals the reload pair loads FFFFh.
- R9: In up/down mode every reload sets the overflow flag and toggles the external flag, and the external flag does not drive `irqReq`.
- R10: Baud mode is selected when reg 0 bit 4 or bit 5 is set. Rollover loads the reload pair, does not set the overflow flag, and drives `baudPulse` high for exactly one cycle. A `trigPin` falling edge with external enable set sets the external flag.
- R11: `irqReq` is the overflow flag OR the external flag, with the external flag left out in up/down mode. A flag is cleared only by writing 0 to its bit. Writing 1 leaves it unchanged.
- R12: A write to a count byte takes effect and cancels all counting and trigger events in that same cycle.
- R13: Register map:
  - 0: control A (bit 0 run, bit 1 pin select, bit 2 capture select, bit 3 external enable, bit 4 receive clock, bit 5 transmit clock, bit 6 overflow flag, bit 7 external flag).
  - 1: control B (bits [7:5] read 0).
  - 2 and 3: count low and high bytes.
  - 4 and 5: reload low and high bytes.
  - 6 and 7: read 0 and ignore writes.
  - A hardware capture wins over a software reload write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr` (combinational) |
| cntPin | input | 1 | External count pin |
| trigPin | input | 1 | External trigger / direction pin |
| irqReq | output | 1 | Interrupt request |
| ovfFlag | output | 1 | Overflow flag |
| extFlag | output | 1 | External flag |
| baudPulse | output | 1 | One-cycle rollover pulse in baud mode |

## Verification
Two kinds of events can fall in the same clock cycle. The first is a software write to a count byte together with a count edge. The second is a trigger falling edge together with a rollover, or a capture together with a software reload write. The bench provokes the first kind by sweeping the write across every cycle offset around a synchronized count edge. A long pseudo-random phase, with pin toggles and writes landing anywhere, covers the other collisions. A behavioural model in the bench predicts the full register file and all outputs on every clock, so each collision is judged by comparing the count, reload and flag values with the priority rules in R12 and R13.

// File: rtl/ft16_pkg.sv
package ft16_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTLA   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTLB   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_RLD_LO = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_RLD_HI = 3'd5;

  typedef enum logic [1:0] {
    MODE_CAPT   = 2'd0,
    MODE_RELOAD = 2'd1,
    MODE_UPDOWN = 2'd2,
    MODE_BAUD   = 2'd3
  } ftMode_e;

  // strobes from control to datapath, at most one count action active
  typedef struct packed {
    logic clr;
    logic ldReload;
    logic ldOnes;
    logic inc;
    logic dec;
    logic capture;
    logic baudPulse;
  } ftStrobe_t;
endpackage

// File: rtl/ft16_edge_sync.sv
module ft16_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic level,
  output logic fall
);
  logic [STAGES:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else       shiftQ <= {shiftQ[STAGES-1:0], pinIn};
  end

  assign level = shiftQ[STAGES-1];
  assign fall  = shiftQ[STAGES] & ~shiftQ[STAGES-1];
endmodule

// File: rtl/ft16_ctrl.sv
module ft16_ctrl
  import ft16_pkg::*;
#(
  parameter int PRE_MID_LOG = 4,
  parameter int PRE_HI_LOG  = 8,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              cntPin,
  input  logic              trigPin,
  input  logic              countIsMax,
  input  logic              countIsReload,
  output ftStrobe_t         strobe,
  output ftMode_e           curMode,
  output logic              ovfFlag,
  output logic              extFlag,
  output logic [BYTE_W-1:0] ctlAByte,
  output logic [BYTE_W-1:0] ctlBByte
);
  localparam int PRE_W = PRE_HI_LOG;
  localparam int DIV_W = $clog2(DIV_SLOW);
  localparam logic [PRE_W-1:0] PRE_LIM_MID = PRE_W'((1 << PRE_MID_LOG) - 1);
  localparam logic [PRE_W-1:0] PRE_LIM_HI  = PRE_W'((1 << PRE_HI_LOG) - 1);
  localparam logic [DIV_W-1:0] DIV_LIM_SLOW = DIV_W'(DIV_SLOW - 1);
  localparam logic [DIV_W-1:0] DIV_LIM_FAST = DIV_W'(DIV_FAST - 1);

  // control A fields
  logic runEn, pinSel, capSel, extEn, rxClk, txClk;
  // control B fields
  logic downEn, autoClr, fastDiv;
  logic [1:0] preSel;

  logic cntLevel, cntFall, trigLevel, trigFall;

  ft16_edge_sync #(.STAGES(SYNC_STAGES)) u_cntSync (
    .clk(clk), .rstN(rstN), .pinIn(cntPin), .level(cntLevel), .fall(cntFall)
  );
  ft16_edge_sync #(.STAGES(SYNC_STAGES)) u_trigSync (
    .clk(clk), .rstN(rstN), .pinIn(trigPin), .level(trigLevel), .fall(trigFall)
  );

  // prescaler followed by the divide-by-12/4 stage
  logic [PRE_W-1:0] preCnt, preLimit;
  logic [DIV_W-1:0] divCnt, divLimit;
  logic preTick, timerTick;

  always_comb begin
    unique case (preSel)
      2'd0:    preLimit = '0;
      2'd1:    preLimit = PRE_LIM_MID;
      default: preLimit = PRE_LIM_HI;
    endcase
    divLimit  = fastDiv ? DIV_LIM_FAST : DIV_LIM_SLOW;
    preTick   = (preCnt >= preLimit);
    timerTick = preTick && (divCnt >= divLimit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      divCnt <= '0;
    end else begin
      preCnt <= preTick ? '0 : preCnt + 1'b1;
      if (preTick) divCnt <= timerTick ? '0 : divCnt + 1'b1;
    end
  end

  // mode decode
  always_comb begin
    if (rxClk || txClk) curMode = MODE_BAUD;
    else if (capSel)    curMode = MODE_CAPT;
    else if (downEn)    curMode = MODE_UPDOWN;
    else                curMode = MODE_RELOAD;
  end

  logic wrCtlA, wrCtlB, wrCount, countTick, trigEvt;
  logic setOvf, setExt, togExt;

  assign wrCtlA    = wrEn && (addr == ADDR_CTLA);
  assign wrCtlB    = wrEn && (addr == ADDR_CTLB);
  assign wrCount   = wrEn && ((addr == ADDR_CNT_LO) || (addr == ADDR_CNT_HI));
  assign countTick = runEn && (pinSel ? cntFall : timerTick) && !wrCount;
  assign trigEvt   = extEn && trigFall && !wrCount;

  always_comb begin
    strobe = '0;
    setOvf = 1'b0;
    setExt = 1'b0;
    togExt = 1'b0;
    unique case (curMode)
      MODE_CAPT: begin
        if (trigEvt) begin
          strobe.capture = 1'b1;
          setExt         = 1'b1;
        end
        if (countTick && countIsMax) setOvf = 1'b1;
        if (trigEvt && autoClr) strobe.clr = 1'b1;
        else if (countTick)     strobe.inc = 1'b1;
      end
      MODE_RELOAD: begin
        if (trigEvt) begin
          strobe.ldReload = 1'b1;
          setExt          = 1'b1;
        end
        if (countTick) begin
          if (countIsMax) begin
            strobe.ldReload = 1'b1;
            setOvf          = 1'b1;
          end else if (!trigEvt) begin
            strobe.inc = 1'b1;
          end
        end
      end
      MODE_UPDOWN: begin
        if (countTick) begin
          if (trigLevel) begin
            if (countIsMax) begin
              strobe.ldReload = 1'b1;
              setOvf          = 1'b1;
              togExt          = 1'b1;
            end else begin
              strobe.inc = 1'b1;
            end
          end else begin
            if (countIsReload) begin
              strobe.ldOnes = 1'b1;
              setOvf        = 1'b1;
              togExt        = 1'b1;
            end else begin
              strobe.dec = 1'b1;
            end
          end
        end
      end
      default: begin
        if (trigEvt) setExt = 1'b1;
        if (countTick) begin
          if (countIsMax) begin
            strobe.ldReload  = 1'b1;
            strobe.baudPulse = 1'b1;
          end else begin
            strobe.inc = 1'b1;
          end
        end
      end
    endcase
  end

  // control registers and sticky flags
  logic ovfKeep, extKeep;
  assign ovfKeep = wrCtlA ? (ovfFlag & wrData[6]) : ovfFlag;
  assign extKeep = wrCtlA ? (extFlag & wrData[7]) : extFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {runEn, pinSel, capSel, extEn, rxClk, txClk} <= '0;
      {downEn, autoClr, fastDiv} <= '0;
      preSel  <= '0;
      ovfFlag <= 1'b0;
      extFlag <= 1'b0;
    end else begin
      if (wrCtlA) begin
        runEn  <= wrData[0];
        pinSel <= wrData[1];
        capSel <= wrData[2];
        extEn  <= wrData[3];
        rxClk  <= wrData[4];
        txClk  <= wrData[5];
      end
      if (wrCtlB) begin
        downEn  <= wrData[0];
        autoClr <= wrData[1];
        fastDiv <= wrData[2];
        preSel  <= wrData[4:3];
      end
      ovfFlag <= ovfKeep | setOvf;
      extFlag <= (extKeep | setExt) ^ togExt;
    end
  end

  assign ctlAByte = {extFlag, ovfFlag, txClk, rxClk, extEn, capSel, pinSel, runEn};
  assign ctlBByte = {3'b000, preSel, fastDiv, autoClr, downEn};
endmodule

// File: rtl/ft16_datapath.sv
module ft16_datapath
  import ft16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  ftStrobe_t         strobe,
  output logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  reloadVal,
  output logic              baudPulse,
  output logic              countIsMax,
  output logic              countIsReload
);
  assign countIsMax    = &countVal;
  assign countIsReload = (countVal == reloadVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (wrEn && addr == ADDR_CNT_LO) begin
      countVal[BYTE_W-1:0] <= wrData;
    end else if (wrEn && addr == ADDR_CNT_HI) begin
      countVal[CNT_W-1:BYTE_W] <= wrData;
    end else if (strobe.clr) begin
      countVal <= '0;
    end else if (strobe.ldReload) begin
      countVal <= reloadVal;
    end else if (strobe.ldOnes) begin
      countVal <= '1;
    end else if (strobe.inc) begin
      countVal <= countVal + 1'b1;
    end else if (strobe.dec) begin
      countVal <= countVal - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= '0;
    end else if (strobe.capture) begin
      reloadVal <= countVal;
    end else if (wrEn && addr == ADDR_RLD_LO) begin
      reloadVal[BYTE_W-1:0] <= wrData;
    end else if (wrEn && addr == ADDR_RLD_HI) begin
      reloadVal[CNT_W-1:BYTE_W] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) baudPulse <= 1'b0;
    else       baudPulse <= strobe.baudPulse;
  end
endmodule

// File: rtl/flex_timer16.sv
module flex_timer16
  import ft16_pkg::*;
#(
  parameter int PRE_MID_LOG = 4,
  parameter int PRE_HI_LOG  = 8,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  input  logic              cntPin,
  input  logic              trigPin,
  output logic              irqReq,
  output logic              ovfFlag,
  output logic              extFlag,
  output logic              baudPulse
);
  ftStrobe_t         strobe;
  ftMode_e           curMode;
  logic [CNT_W-1:0]  countVal, reloadVal;
  logic              countIsMax, countIsReload;
  logic [BYTE_W-1:0] ctlAByte, ctlBByte;

  ft16_ctrl #(
    .PRE_MID_LOG(PRE_MID_LOG), .PRE_HI_LOG(PRE_HI_LOG),
    .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .addr(busAddr), .wrData(busWrData),
    .cntPin(cntPin), .trigPin(trigPin),
    .countIsMax(countIsMax), .countIsReload(countIsReload),
    .strobe(strobe), .curMode(curMode), .ovfFlag(ovfFlag), .extFlag(extFlag),
    .ctlAByte(ctlAByte), .ctlBByte(ctlBByte)
  );

  ft16_datapath u_dp (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .addr(busAddr), .wrData(busWrData),
    .strobe(strobe), .countVal(countVal), .reloadVal(reloadVal),
    .baudPulse(baudPulse), .countIsMax(countIsMax), .countIsReload(countIsReload)
  );

  assign irqReq = ovfFlag | (extFlag & (curMode != MODE_UPDOWN));

  always_comb begin
    unique case (busAddr)
      ADDR_CTLA:   busRdData = ctlAByte;
      ADDR_CTLB:   busRdData = ctlBByte;
      ADDR_CNT_LO: busRdData = countVal[BYTE_W-1:0];
      ADDR_CNT_HI: busRdData = countVal[CNT_W-1:BYTE_W];
      ADDR_RLD_LO: busRdData = reloadVal[BYTE_W-1:0];
      ADDR_RLD_HI: busRdData = reloadVal[CNT_W-1:BYTE_W];
      default:     busRdData = '0;
    endcase
  end
endmodule

// File: rtl/ft16_checker.sv
module ft16_checker
  import ft16_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BYTE_W-1:0] busWrData,
  input logic              ovfFlag,
  input logic              baudPulse,
  input ftMode_e           curMode,
  input logic [CNT_W-1:0]  countVal,
  input logic [CNT_W-1:0]  reloadVal
);
  AST_OVF_FROM_MAX: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ovfFlag) && $past(curMode) != MODE_UPDOWN) |-> $past(countVal) == '1); // R3
  AST_BAUD_NO_OVF: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curMode) == MODE_BAUD) |-> !$rose(ovfFlag)); // R10
  AST_PULSE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    baudPulse |-> countVal == $past(reloadVal)); // R10
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    baudPulse |=> !baudPulse); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(busWrEn && busAddr == ADDR_CTLA)) |=> ovfFlag); // R11
  AST_CNT_WR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    $past(busWrEn && busAddr == ADDR_CNT_LO) |-> countVal[BYTE_W-1:0] == $past(busWrData)); // R12
endmodule

bind flex_timer16 ft16_checker u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
  .ovfFlag(ovfFlag), .baudPulse(baudPulse), .curMode(curMode),
  .countVal(countVal), .reloadVal(reloadVal)
);

// File: tb/flex_timer16_tb.sv
`timescale 1ns/100ps
module flex_timer16_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic cntPin = 1'b0, trigPin = 1'b0;
  logic irqReq, ovfFlag, extFlag, baudPulse;

  flex_timer16 u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .cntPin(cntPin), .trigPin(trigPin),
    .irqReq(irqReq), .ovfFlag(ovfFlag), .extFlag(extFlag), .baudPulse(baudPulse)
  );

  always #4 clk = ~clk;

  int testsRun = 0, testsFailed = 0;
  string curReq = "R1";
  bit finished = 0;

  // reference model state
  bit mS1c, mS2c, mPc, mS1t, mS2t, mPt;
  int mPreCnt, mDivCnt;
  bit mRun, mPinSel, mCap, mExtEn, mRx, mTx, mOvf, mExt;
  bit mDown, mAuto, mFast;
  int mPre;
  int mCnt, mRld;
  bit mPulse;

  task automatic check(string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    int expByte;
    bit ud;
    ud = !(mRx || mTx) && !mCap && mDown;
    for (int a = 0; a < 8; a++) begin
      busAddr = 3'(a);
      #0.4;
      case (a)
        0: expByte = {mExt, mOvf, mTx, mRx, mExtEn, mCap, mPinSel, mRun};
        1: expByte = (mPre << 3) | (mFast << 2) | (mAuto << 1) | mDown;
        2: expByte = mCnt & 255;
        3: expByte = (mCnt >> 8) & 255;
        4: expByte = mRld & 255;
        5: expByte = (mRld >> 8) & 255;
        default: expByte = 0;
      endcase
      check($sformatf("reg%0d", a), busRdData, expByte);
    end
    check("ovfFlag", ovfFlag, mOvf);
    check("extFlag", extFlag, mExt);
    check("irqReq", irqReq, mOvf || (mExt && !ud));
    check("baudPulse", baudPulse, mPulse);
  endtask

  // one clock: predict from current inputs, take the edge, commit, compare
  task automatic step();
    bit fallC, fallT, dirUp, preTick, tTick, cntWr, tick, trg;
    bit baud, capt, ud, rl, sOvf, sExt, tExt, nPulse, keepO, keepE;
    int preLim, divLim, nCnt, nRld, d;
    fallC = mPc && !mS2c;
    fallT = mPt && !mS2t;
    dirUp = mS2t;
    preLim = (mPre == 0) ? 0 : (mPre == 1) ? 15 : 255;
    preTick = mPreCnt >= preLim;
    divLim = mFast ? 3 : 11;
    tTick = preTick && (mDivCnt >= divLim);
    cntWr = busWrEn && (busAddr == 2 || busAddr == 3);
    tick = mRun && (mPinSel ? fallC : tTick) && !cntWr;
    trg = mExtEn && fallT && !cntWr;
    baud = mRx || mTx;
    capt = !baud && mCap;
    ud = !baud && !mCap && mDown;
    rl = !baud && !mCap && !mDown;
    nCnt = mCnt; nRld = mRld;
    sOvf = 0; sExt = 0; tExt = 0; nPulse = 0;
    if (capt) begin
      if (trg) begin nRld = mCnt; sExt = 1; end
      if (tick && mCnt == 65535) sOvf = 1;
      if (trg && mAuto) nCnt = 0;
      else if (tick) nCnt = (mCnt + 1) & 65535;
    end else if (rl) begin
      if (trg) begin nCnt = mRld; sExt = 1; end
      if (tick) begin
        if (mCnt == 65535) begin nCnt = mRld; sOvf = 1; end
        else if (!trg) nCnt = mCnt + 1;
      end
    end else if (ud) begin
      if (tick) begin
        if (dirUp) begin
          if (mCnt == 65535) begin nCnt = mRld; sOvf = 1; tExt = 1; end
          else nCnt = mCnt + 1;
        end else begin
          if (mCnt == mRld) begin nCnt = 65535; sOvf = 1; tExt = 1; end
          else nCnt = (mCnt - 1) & 65535;
        end
      end
    end else begin
      if (trg) sExt = 1;
      if (tick) begin
        if (mCnt == 65535) begin nCnt = mRld; nPulse = 1; end
        else nCnt = mCnt + 1;
      end
    end
    keepO = mOvf; keepE = mExt;
    d = busWrData;
    if (busWrEn) begin
      case (busAddr)
        3'd0: begin
          keepO = mOvf && d[6];
          keepE = mExt && d[7];
        end
        3'd2: nCnt = (mCnt & 16'hFF00) | d;
        3'd3: nCnt = (mCnt & 16'h00FF) | (d << 8);
        3'd4: if (!(capt && trg)) nRld = (mRld & 16'hFF00) | d;
        3'd5: if (!(capt && trg)) nRld = (mRld & 16'h00FF) | (d << 8);
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    if (busWrEn && busAddr == 0) begin
      mRun = d[0]; mPinSel = d[1]; mCap = d[2]; mExtEn = d[3]; mRx = d[4]; mTx = d[5];
    end
    if (busWrEn && busAddr == 1) begin
      mDown = d[0]; mAuto = d[1]; mFast = d[2]; mPre = (d >> 3) & 3;
    end
    busWrEn = 1'b0;
    mOvf = keepO || sOvf;
    mExt = (keepE || sExt) ^ tExt;
    mCnt = nCnt; mRld = nRld; mPulse = nPulse;
    if (preTick) mDivCnt = tTick ? 0 : mDivCnt + 1;
    mPreCnt = preTick ? 0 : mPreCnt + 1;
    mPc = mS2c; mS2c = mS1c; mS1c = cntPin;
    mPt = mS2t; mS2t = mS1t; mS1t = trigPin;
    compareAll();
  endtask

  task automatic wr(int a, int v);
    busAddr = 3'(a);
    busWrData = 8'(v);
    busWrEn = 1'b1;
    step();
  endtask

  task automatic pulseCnt(int n);
    for (int i = 0; i < n; i++) begin
      cntPin = 1'b1; repeat (3) step();
      cntPin = 1'b0; repeat (3) step();
    end
  endtask

  task automatic pulseTrig();
    trigPin = 1'b1; repeat (3) step();
    trigPin = 1'b0; repeat (4) step();
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    #1 compareAll();                   // R1 reset state
    curReq = "R1";  repeat (3) step();

    curReq = "R13"; wr(1, 8'hFF); wr(1, 8'h00);
    wr(4, 8'h34); wr(5, 8'h12); wr(6, 8'h55); wr(7, 8'hAA);

    curReq = "R2";  wr(1, 8'h04); wr(0, 8'h05); repeat (40) step();
    wr(1, 8'h08); repeat (450) step();
    wr(1, 8'h10); repeat (300) step();
    wr(0, 8'h04); repeat (20) step();
    wr(1, 8'h04); wr(0, 8'h07); pulseCnt(5);
    wr(0, 8'h06); pulseCnt(2);

    curReq = "R3";  wr(0, 8'h07); wr(2, 8'hF0); wr(3, 8'hFF); pulseCnt(20);
    curReq = "R11"; wr(0, 8'hC7); repeat (3) step(); wr(0, 8'h07); repeat (2) step();

    curReq = "R4";  wr(0, 8'h0F); pulseCnt(3); pulseTrig(); pulseCnt(2);
    wr(0, 8'h87); wr(0, 8'h07); pulseTrig(); pulseCnt(1);

    curReq = "R5";  wr(1, 8'h02); wr(0, 8'h0F); pulseCnt(4); pulseTrig(); pulseCnt(3);
    wr(1, 8'h00);

    curReq = "R6";  wr(4, 8'hF8); wr(5, 8'hFF); wr(2, 8'hFA); wr(3, 8'hFF);
    wr(0, 8'h0B); pulseCnt(12); wr(0, 8'h0B); pulseTrig(); pulseCnt(2);

    curReq = "R8";  wr(1, 8'h01); wr(4, 8'h10); wr(5, 8'h00); wr(2, 8'h12); wr(3, 8'h00);
    wr(0, 8'h03); pulseCnt(4);
    curReq = "R9";  wr(0, 8'h83); repeat (3) step();
    curReq = "R7";  trigPin = 1'b1; repeat (3) step(); pulseCnt(3);
    trigPin = 1'b0; repeat (3) step();

    curReq = "R10"; wr(1, 8'h04); wr(4, 8'hFC); wr(5, 8'hFF); wr(2, 8'hFC); wr(3, 8'hFF);
    wr(0, 8'h19); repeat (60) step(); pulseTrig(); wr(0, 8'h29); repeat (30) step();

    curReq = "R12"; wr(1, 8'h00); wr(0, 8'h0F);
    for (int off = 0; off < 6; off++) begin
      cntPin = 1'b1; trigPin = 1'b1; repeat (3) step();
      cntPin = 1'b0; trigPin = 1'b0; repeat (off) step();
      wr(2, off); repeat (4) step();
    end

    curReq = "R11 mixed";
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cntPin = lfsr[0];
      if (lfsr[7:5] == 3'd0) trigPin = ~trigPin;
      if (lfsr[11:8] == 4'd0) begin
        busAddr = lfsr[14:12];
        busWrData = (lfsr[14:12] == 3'd1) ? {lfsr[4:3] & 2'b01, lfsr[2:0]} & 8'h0F
                                          : {lfsr[3:0], lfsr[15:12]};
        busWrEn = 1'b1;
      end
      step();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule